// File: doc/BRIEF.md
# LDPC Bit-Node Update Unit

This block performs the bit-node half of one iteration of a log-likelihood-ratio LDPC decoder for a node of column weight three. Each accepted input carries four values: the channel soft value for one codeword bit and the three check-to-bit messages arriving on that node's edges. One cycle later the block presents three bit-to-check messages, the a-posteriori total for the bit, and the hard decision taken from that total.

Each outgoing message adds the channel value to the incoming messages of the other two edges. The message on its own edge is excluded, so no information returns to the check it came from. The channel value arrives as 5-bit two's complement with 4 fraction bits. Messages are 6-bit two's complement with 5 fraction bits, so the channel value is shifted left one place before any addition. Sums are formed at full width. Only the outgoing messages are clipped, and the clipping is symmetric so that a message can always be negated safely.

An init input selects the first pass of decoding. In that pass every outgoing message is the aligned channel value alone, and the incoming messages are ignored.

Top module: `bitnode_update`

## Requirements
- R1: `out_valid_o` is 0 while reset is held. In every later cycle it equals the value `in_valid_i` had at the previous rising clock edge.
- R2: When `init_i` is 1, each of the three outgoing messages equals 2×channel value, clipped to the range −31..+31. The incoming messages have no effect. A channel value of −16 therefore yields −31.
- R3: When `init_i` is 0, outgoing message k (bits 6k+5..6k of `v2c_o`, two's complement) equals 2×channel plus the sum of the incoming messages on the two edges other than k, clipped to −31..+31. Edge k's message is bits 6k+5..6k of `c2v_i`.
- R4: No outgoing message ever takes the value −32 (binary 100000).
- R5: `app_o` is a 9-bit two's complement value. In update mode it equals 2×channel plus the sum of all three incoming messages, without clipping. In init mode it equals 2×channel.
- R6: `hard_o` is 1 exactly when `app_o` is negative, and 0 otherwise. A total of zero gives 0.
- R7: While `in_valid_i` is 0, `v2c_o`, `app_o` and `hard_o` keep the values they were last given.
- R8: After reset, `v2c_o`, `app_o` and `hard_o` are all zero until the first valid input has been registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input set valid this cycle |
| init_i | input | 1 | 1: init pass, 0: update pass |
| chan_i | input | 5 | Channel value, signed, 4 fraction bits |
| c2v_i | input | 18 | Three check-to-bit messages, 6 bits each, edge 0 in the low bits |
| out_valid_o | output | 1 | Outputs updated from the previous cycle's input |
| v2c_o | output | 18 | Three bit-to-check messages, 6 bits each, edge 0 in the low bits |
| app_o | output | 9 | A-posteriori total, signed, 5 fraction bits |
| hard_o | output | 1 | Hard decision, 1 when the total is negative |

## Verification
The assertions check the timing and value rules on every cycle:
- the one-cycle valid latency;
- that no message ever reaches the excluded negative extreme;
- that the hard decision agrees with the sign of the total;
- that outputs hold while no input is offered.

The arithmetic can only be shown by the bench's scenarios, which compare results against a model computed from the requirements. This covers the exclusion of each edge's own message, the clipping at both extremes, init mode ignoring the messages, and the zero-total sign case. Back-to-back and randomised inputs show that results leave the pipeline in order, one per accepted input.

// File: rtl/vnu_pkg.sv
package vnu_pkg;
  localparam int VN_DEG    = 3;
  localparam int CH_W      = 5;
  localparam int MSG_W     = 6;
  localparam int CH_ALIGN  = 1;
  localparam int SUM_W     = MSG_W + $clog2(VN_DEG + 1) + 1;
endpackage

// File: rtl/vnu_align.sv
module vnu_align #(
  parameter int CH_W  = 5,
  parameter int ALIGN = 1,
  parameter int SUM_W = 9
) (
  input  logic [CH_W-1:0]         chan_i,
  output logic signed [SUM_W-1:0] chan_o
);
  logic signed [SUM_W-1:0] ext;
  assign ext    = SUM_W'($signed(chan_i));
  assign chan_o = ext <<< ALIGN;
endmodule

// File: rtl/vnu_sum.sv
module vnu_sum #(
  parameter int DEG   = 3,
  parameter int MSG_W = 6,
  parameter int SUM_W = 9
) (
  input  logic [DEG*MSG_W-1:0]    msg_i,
  output logic signed [SUM_W-1:0] sum_o
);
  always_comb begin
    logic signed [SUM_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < DEG; k++) begin
      acc = acc + SUM_W'($signed(msg_i[k*MSG_W +: MSG_W]));
    end
    sum_o = acc;
  end
endmodule

// File: rtl/vnu_sat.sv
module vnu_sat #(
  parameter int IN_W  = 9,
  parameter int OUT_W = 6
) (
  input  logic signed [IN_W-1:0] val_i,
  output logic [OUT_W-1:0]       val_o
);
  localparam logic signed [IN_W-1:0] POS_LIM = IN_W'(2**(OUT_W-1) - 1);
  localparam logic signed [IN_W-1:0] NEG_LIM = -POS_LIM;

  // symmetric clip: most negative code is never produced
  always_comb begin
    if (val_i > POS_LIM)      val_o = POS_LIM[OUT_W-1:0];
    else if (val_i < NEG_LIM) val_o = NEG_LIM[OUT_W-1:0];
    else                      val_o = val_i[OUT_W-1:0];
  end
endmodule

// File: rtl/bitnode_update.sv
module bitnode_update
  import vnu_pkg::*;
#(
  parameter int DEG   = VN_DEG,
  parameter int CHW   = CH_W,
  parameter int MW    = MSG_W,
  parameter int ALIGN = CH_ALIGN,
  parameter int SW    = SUM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              init_i,
  input  logic [CHW-1:0]    chan_i,
  input  logic [DEG*MW-1:0] c2v_i,
  output logic              out_valid_o,
  output logic [DEG*MW-1:0] v2c_o,
  output logic [SW-1:0]     app_o,
  output logic              hard_o
);
  logic signed [SW-1:0] chan_al;
  logic signed [SW-1:0] msg_sum;
  logic signed [SW-1:0] total;
  logic signed [SW-1:0] app_d;
  logic [DEG*MW-1:0]    v2c_d;

  vnu_align #(.CH_W(CHW), .ALIGN(ALIGN), .SUM_W(SW)) u_align (
    .chan_i (chan_i),
    .chan_o (chan_al)
  );

  vnu_sum #(.DEG(DEG), .MSG_W(MW), .SUM_W(SW)) u_sum (
    .msg_i (c2v_i),
    .sum_o (msg_sum)
  );

  assign total = chan_al + msg_sum;
  assign app_d = init_i ? chan_al : total;

  for (genvar k = 0; k < DEG; k++) begin : g_edge
    logic signed [SW-1:0] own;
    logic signed [SW-1:0] ext;
    assign own = SW'($signed(c2v_i[k*MW +: MW]));
    // extrinsic: drop this edge's own contribution
    assign ext = init_i ? chan_al : (total - own);
    vnu_sat #(.IN_W(SW), .OUT_W(MW)) u_sat (
      .val_i (ext),
      .val_o (v2c_d[k*MW +: MW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      v2c_o       <= '0;
      app_o       <= '0;
      hard_o      <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        v2c_o  <= v2c_d;
        app_o  <= app_d;
        hard_o <= app_d[SW-1];
      end
    end
  end
endmodule

// File: rtl/bitnode_update_chk.sv
module bitnode_update_chk #(
  parameter int DEG = 3,
  parameter int MW  = 6,
  parameter int SW  = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              out_valid_o,
  input logic [DEG*MW-1:0] v2c_o,
  input logic [SW-1:0]     app_o,
  input logic              hard_o
);
  // R1
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  // R1
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  for (genvar k = 0; k < DEG; k++) begin : g_msg
    // R4
    no_neg_extreme_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v2c_o[k*MW +: MW] != {1'b1, {(MW-1){1'b0}}});
  end

  // R6
  hard_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (hard_o == ($signed(app_o) < 0)));
  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(v2c_o) && $stable(app_o) && $stable(hard_o)));
endmodule

bind bitnode_update bitnode_update_chk #(.DEG(DEG), .MW(MW), .SW(SW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o),
  .v2c_o       (v2c_o),
  .app_o       (app_o),
  .hard_o      (hard_o)
);

// File: tb/bitnode_update_bench.sv
module bitnode_update_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        init_i = 1'b0;
  logic [4:0]  chan_i = '0;
  logic [17:0] c2v_i = '0;
  logic        out_valid_o;
  logic [17:0] v2c_o;
  logic [8:0]  app_o;
  logic        hard_o;

  int n_chk = 0;
  int n_fail = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  typedef struct {
    bit init;
    int v0, v1, v2;
    int app;
    bit hard;
  } exp_t;
  exp_t q[$];
  exp_t last;
  bit have_last = 1'b0;

  always #5 clk_i = ~clk_i;

  bitnode_update u_bitnode_update (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .init_i(init_i),
    .chan_i(chan_i), .c2v_i(c2v_i), .out_valid_o(out_valid_o),
    .v2c_o(v2c_o), .app_o(app_o), .hard_o(hard_o)
  );

  function automatic int clip31(int x);
    if (x > 31) return 31;
    if (x < -31) return -31;
    return x;
  endfunction

  function automatic int msg_at(int k);
    return int'($signed(v2c_o[k*6 +: 6]));
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(bit init, int ch, int m0, int m1, int m2);
    exp_t e;
    int a, tot;
    @(negedge clk_i);
    a = 2 * ch;
    tot = a + m0 + m1 + m2;
    e.init = init;
    e.app  = init ? a : tot;
    e.v0   = init ? clip31(a) : clip31(tot - m0);
    e.v1   = init ? clip31(a) : clip31(tot - m1);
    e.v2   = init ? clip31(a) : clip31(tot - m2);
    e.hard = (e.app < 0);
    q.push_back(e);
    init_i = init;
    chan_i = ch[4:0];
    c2v_i  = {m2[5:0], m1[5:0], m0[5:0]};
    in_valid_i = 1'b1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      in_valid_i = 1'b0;
      chan_i = 5'h0b;
      c2v_i  = 18'h2a5c3;
      init_i = (i % 2) == 1;
    end
  endtask

  // monitor / scoreboard
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && started) begin
      if (out_valid_o) begin
        if (q.size() == 0) begin
          check(1'b0, "R1", "out_valid without pending input", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(msg_at(0) == e.v0, e.init ? "R2" : "R3", "v2c edge0", msg_at(0), e.v0);
          check(msg_at(1) == e.v1, e.init ? "R2" : "R3", "v2c edge1", msg_at(1), e.v1);
          check(msg_at(2) == e.v2, e.init ? "R2" : "R3", "v2c edge2", msg_at(2), e.v2);
          check(msg_at(0) != -32 && msg_at(1) != -32 && msg_at(2) != -32,
                "R4", "message at -32", msg_at(0), e.v0);
          check(int'($signed(app_o)) == e.app, "R5", "app", int'($signed(app_o)), e.app);
          check(hard_o == e.hard, "R6", "hard", int'(hard_o), int'(e.hard));
          last = e;
          have_last = 1'b1;
        end
      end else if (have_last) begin
        check(msg_at(0) == last.v0 && msg_at(1) == last.v1 && msg_at(2) == last.v2,
              "R7", "v2c hold edge0", msg_at(0), last.v0);
        check(int'($signed(app_o)) == last.app && hard_o == last.hard,
              "R7", "app hold", int'($signed(app_o)), last.app);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R8 and R1: reset state
    check(out_valid_o == 1'b0, "R1", "valid in reset", int'(out_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(v2c_o == '0, "R8", "v2c after reset", int'(v2c_o), 0);
    check(app_o == '0 && hard_o == 1'b0, "R8", "app after reset", int'(app_o), 0);
    check(out_valid_o == 1'b0, "R1", "valid after reset", int'(out_valid_o), 0);
    started = 1'b1;

    // R2: init mode, messages ignored
    send(1, 5, 20, -7, 3);
    send(1, -16, 31, 31, 31);
    send(1, 15, -32, -32, -32);
    idle(2);
    // R3: exclusion of own edge
    send(0, 0, 10, -3, 1);
    send(0, 3, 4, -5, 7);
    // R4: saturation at both extremes
    send(0, 15, 31, 31, 31);
    send(0, -16, -32, -32, -32);
    // R6: zero and minus-one totals
    send(0, 0, 0, 0, 0);
    send(0, 0, -1, 0, 0);
    idle(3);
    for (int i = 0; i < 60; i++) begin
      send($urandom_range(0, 3) == 0, int'($urandom_range(0, 31)) - 16,
           int'($urandom_range(0, 63)) - 32, int'($urandom_range(0, 63)) - 32,
           int'($urandom_range(0, 63)) - 32);
      if (i % 7 == 0) idle(2);
    end
    idle(4);
    check(q.size() == 0, "R1", "results outstanding", q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule